// File: doc/BRIEF.md
# Nibble ALU with Skip Generation

This block is the 4-bit datapath of a small microcontroller core. Conditional control flow comes from operation results: instead of setting status flags, the arithmetic, increment, decrement and compare operations raise a request to skip the following instruction. The block holds the carry flag in a register and keeps a skip request latched until the sequencer acknowledges it. A taken skip costs the sequencer extra machine cycles, so the request must not be lost in the meantime.

The sequencer presents an operation code, the accumulator value and a second operand, and pulses `issue_i` in the cycle that completes the instruction. The operand is an immediate, a memory nibble or a register. One clock later the block presents the registered result with a one-cycle write strobe, the updated carry flag, and the skip request if its condition held. For the increment and decrement operations the value being stepped arrives on `opnd_i`. For compare-with-register the sequencer routes the register onto `acc_i`.

Top module: `nib_alu`

## Requirements
- R1: The block samples an operation only on a rising edge where `issue_i` is 1. Its effects show on `res_o`, `res_we_o`, `cy_o` and `skip_o` right after that edge. The operation codes are: 0 add-skip, 1 add-carry, 2 AND, 3 OR, 4 XOR, 5 rotate-right-through-carry, 6 complement, 7 increment-skip, 8 decrement-skip, 9 skip-if-equal, 10 set-carry, 11 clear-carry, 12 invert-carry, 13 test-carry. Codes 14 and 15 have no effect.
- R2: Add-skip (0) writes (acc+opnd) mod 16. It requests a skip exactly when the addition carries out of bit 3, and it leaves the carry flag unchanged.
- R3: Add-carry (1) writes the low 4 bits of acc+opnd+CY and loads the carry-out into CY. It never requests a skip.
- R4: AND (2), OR (3) and XOR (4) write the bitwise combination of acc and opnd. They do not skip and leave CY unchanged.
- R5: Rotate-right-through-carry (5) writes {CY, acc[3:1]}, loads acc[0] into CY and does not skip.
- R6: Complement (6) writes ~acc, does not skip and leaves CY unchanged.
- R7: Increment-skip (7) writes (opnd+1) mod 16 and requests a skip when the result is 0. CY is unchanged.
- R8: Decrement-skip (8) writes (opnd-1) mod 16 and requests a skip when the result is 0xF. CY is unchanged.
- R9: Skip-if-equal (9) writes nothing: `res_we_o` stays 0 and `res_o` holds. It requests a skip when acc equals opnd, and CY is unchanged.
- R10: Set-carry (10) loads CY with 1, clear-carry (11) with 0, and invert-carry (12) with ~CY. Test-carry (13) requests a skip when CY is 1 and leaves CY unchanged. None of these four writes a result.
- R11: A skip request stays high until a rising edge with `skip_ack_i`=1, which clears it. Any issued operation replaces the latch with that operation's own skip condition, and this takes priority over the acknowledge.
- R12: Synchronous reset clears `res_o`, `res_we_o`, `cy_o` and `skip_o` to 0.
- R13: On edges without `issue_i`, `res_we_o` is 0 and `res_o` and `cy_o` hold their values whatever the other inputs do. `res_o` also holds across operations that do not write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| issue_i | input | 1 | Instruction completes this cycle; execute `op_i` |
| op_i | input | 4 | Operation code (see R1) |
| acc_i | input | W (4) | Accumulator value, or register for compare |
| opnd_i | input | W (4) | Immediate, memory nibble or register operand |
| skip_ack_i | input | 1 | Sequencer has consumed the skip request |
| res_o | output | W (4) | Registered result |
| res_we_o | output | 1 | One-cycle strobe: write `res_o` to its destination |
| cy_o | output | 1 | Carry flag |
| skip_o | output | 1 | Latched skip-next-instruction request |

## Verification
A corrupted carry register shows on `cy_o` one edge after the fault. It also shows one instruction later in the result of an add-carry or rotate, or in the skip of a test-carry. A skip latch that drops early or sticks shows on `skip_o` during idle cycles, before and after the acknowledge. A wrong skip condition shows right after the issuing edge. The bench runs every operation over all accumulator, operand and carry combinations, so a fault in any single decode arm reaches the ports within two cycles of the first case that uses it.

// File: rtl/nalu_pkg.sv
package nalu_pkg;
  localparam int OP_W = 4;

  typedef enum logic [OP_W-1:0] {
    OP_ADDS = 4'd0,
    OP_ADDC = 4'd1,
    OP_AND  = 4'd2,
    OP_OR   = 4'd3,
    OP_XOR  = 4'd4,
    OP_RORC = 4'd5,
    OP_NOT  = 4'd6,
    OP_INCS = 4'd7,
    OP_DECS = 4'd8,
    OP_SKE  = 4'd9,
    OP_SETC = 4'd10,
    OP_CLRC = 4'd11,
    OP_NOTC = 4'd12,
    OP_SKTC = 4'd13,
    OP_NOP0 = 4'd14,
    OP_NOP1 = 4'd15
  } nalu_op_e;
endpackage

// File: rtl/nalu_arith.sv
module nalu_arith
  import nalu_pkg::*;
#(
  parameter int W = 4
) (
  input  nalu_op_e       op,
  input  logic [W-1:0]   a,
  input  logic [W-1:0]   b,
  input  logic           cy,
  output logic [W-1:0]   res,
  output logic           co,
  output logic           skip
);
  localparam logic [W-1:0] ALL_ONES = {W{1'b1}};
  localparam logic [W-1:0] ONE      = W'(1);

  logic [W:0]   sum;
  logic [W-1:0] inc_v;
  logic [W-1:0] dec_v;
  logic         cin;

  assign cin   = (op == OP_ADDC) ? cy : 1'b0;
  assign sum   = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, cin};
  assign inc_v = b + ONE;
  assign dec_v = b - ONE;

  always_comb begin
    res  = sum[W-1:0];
    co   = sum[W];
    skip = 1'b0;
    unique case (op)
      OP_ADDS: skip = sum[W];
      OP_INCS: begin res = inc_v; skip = (inc_v == '0); end
      OP_DECS: begin res = dec_v; skip = (dec_v == ALL_ONES); end
      OP_SKE:  skip = (a == b);
      default: ;
    endcase
  end
endmodule

// File: rtl/nalu_logic.sv
module nalu_logic
  import nalu_pkg::*;
#(
  parameter int W = 4
) (
  input  nalu_op_e       op,
  input  logic [W-1:0]   a,
  input  logic [W-1:0]   b,
  input  logic           cy,
  output logic [W-1:0]   res,
  output logic           co
);
  logic [W-1:0] rot;

  generate
    for (genvar i = 0; i < W - 1; i++) begin : g_rot
      assign rot[i] = a[i+1];
    end
  endgenerate
  assign rot[W-1] = cy;

  assign co = a[0];

  always_comb begin
    unique case (op)
      OP_AND:  res = a & b;
      OP_OR:   res = a | b;
      OP_XOR:  res = a ^ b;
      OP_RORC: res = rot;
      default: res = ~a;
    endcase
  end
endmodule

// File: rtl/nalu_flags.sv
module nalu_flags (
  input  logic clk,
  input  logic rst,
  input  logic issue,
  input  logic cy_wr,
  input  logic cy_nxt,
  input  logic skip_nxt,
  input  logic ack,
  output logic cy_q,
  output logic skip_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      cy_q   <= 1'b0;
      skip_q <= 1'b0;
    end else begin
      if (issue && cy_wr) cy_q <= cy_nxt;
      if (issue)          skip_q <= skip_nxt;
      else if (ack)       skip_q <= 1'b0;
    end
  end

  AST_SKIP_HOLD: assert property (@(posedge clk) disable iff (rst)
    (skip_q && !issue && !ack) |=> skip_q); // R11
  AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (!issue && ack) |=> !skip_q); // R11
  AST_NO_SPUR_SKIP: assert property (@(posedge clk) disable iff (rst)
    (!skip_q && !issue) |=> !skip_q); // R11
  AST_CY_IDLE: assert property (@(posedge clk) disable iff (rst)
    !issue |=> $stable(cy_q)); // R13
endmodule

// File: rtl/nib_alu.sv
module nib_alu
  import nalu_pkg::*;
#(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         issue_i,
  input  logic [3:0]   op_i,
  input  logic [W-1:0] acc_i,
  input  logic [W-1:0] opnd_i,
  input  logic         skip_ack_i,
  output logic [W-1:0] res_o,
  output logic         res_we_o,
  output logic         cy_o,
  output logic         skip_o
);
  nalu_op_e     op;
  logic [W-1:0] ar_res, lg_res, res_nxt;
  logic         ar_co, ar_skip, lg_co;
  logic         we_nxt, cy_wr, cy_nxt, skip_nxt;
  logic         cy_q;

  assign op = nalu_op_e'(op_i);

  nalu_arith #(.W(W)) u_arith (
    .op(op), .a(acc_i), .b(opnd_i), .cy(cy_q),
    .res(ar_res), .co(ar_co), .skip(ar_skip)
  );

  nalu_logic #(.W(W)) u_logic (
    .op(op), .a(acc_i), .b(opnd_i), .cy(cy_q),
    .res(lg_res), .co(lg_co)
  );

  always_comb begin
    res_nxt  = ar_res;
    we_nxt   = 1'b0;
    cy_wr    = 1'b0;
    cy_nxt   = cy_q;
    skip_nxt = 1'b0;
    unique case (op)
      OP_ADDS: begin we_nxt = 1'b1; skip_nxt = ar_skip; end
      OP_ADDC: begin we_nxt = 1'b1; cy_wr = 1'b1; cy_nxt = ar_co; end
      OP_AND, OP_OR, OP_XOR, OP_NOT: begin
        res_nxt = lg_res; we_nxt = 1'b1;
      end
      OP_RORC: begin
        res_nxt = lg_res; we_nxt = 1'b1; cy_wr = 1'b1; cy_nxt = lg_co;
      end
      OP_INCS, OP_DECS: begin we_nxt = 1'b1; skip_nxt = ar_skip; end
      OP_SKE:  skip_nxt = ar_skip;
      OP_SETC: begin cy_wr = 1'b1; cy_nxt = 1'b1; end
      OP_CLRC: begin cy_wr = 1'b1; cy_nxt = 1'b0; end
      OP_NOTC: begin cy_wr = 1'b1; cy_nxt = ~cy_q; end
      OP_SKTC: skip_nxt = cy_q;
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      res_o    <= '0;
      res_we_o <= 1'b0;
    end else begin
      res_we_o <= issue_i && we_nxt;
      if (issue_i && we_nxt) res_o <= res_nxt;
    end
  end

  nalu_flags u_flags (
    .clk(clk), .rst(rst), .issue(issue_i), .cy_wr(cy_wr), .cy_nxt(cy_nxt),
    .skip_nxt(skip_nxt), .ack(skip_ack_i), .cy_q(cy_q), .skip_q(skip_o)
  );

  assign cy_o = cy_q;

  AST_WE_PULSE: assert property (@(posedge clk) disable iff (rst)
    !issue_i |=> !res_we_o); // R13
  AST_RES_HOLD: assert property (@(posedge clk) disable iff (rst)
    !issue_i |=> $stable(res_o)); // R13
  AST_ADDC_NOSKIP: assert property (@(posedge clk) disable iff (rst)
    (issue_i && op_i == 4'd1) |=> !skip_o); // R3
  AST_ADDS_CY_KEEP: assert property (@(posedge clk) disable iff (rst)
    (issue_i && op_i == 4'd0) |=> $stable(cy_o)); // R2
  AST_SKE_NOWRITE: assert property (@(posedge clk) disable iff (rst)
    (issue_i && op_i == 4'd9) |=> (!res_we_o && $stable(res_o))); // R9
  AST_SET_CY: assert property (@(posedge clk) disable iff (rst)
    (issue_i && op_i == 4'd10) |=> cy_o); // R10
  AST_CLR_CY: assert property (@(posedge clk) disable iff (rst)
    (issue_i && op_i == 4'd11) |=> !cy_o); // R10
  AST_NOT_CY: assert property (@(posedge clk) disable iff (rst)
    (issue_i && op_i == 4'd12) |=> (cy_o != $past(cy_o))); // R10
endmodule

// File: tb/nib_alu_tb.sv
module nib_alu_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int W = 4;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         issue_i = 1'b0;
  logic [3:0]   op_i = '0;
  logic [W-1:0] acc_i = '0;
  logic [W-1:0] opnd_i = '0;
  logic         skip_ack_i = 1'b0;
  logic [W-1:0] res_o;
  logic         res_we_o, cy_o, skip_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  logic [W-1:0] m_res = '0;
  logic         m_cy = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  nib_alu #(.W(W)) dut_i (
    .clk(clk), .rst(rst), .issue_i(issue_i), .op_i(op_i), .acc_i(acc_i),
    .opnd_i(opnd_i), .skip_ack_i(skip_ack_i), .res_o(res_o),
    .res_we_o(res_we_o), .cy_o(cy_o), .skip_o(skip_o)
  );

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic issue(input logic [3:0] op, input logic [W-1:0] a,
                       input logic [W-1:0] b, input logic ack);
    @(negedge clk);
    issue_i = 1'b1; op_i = op; acc_i = a; opnd_i = b; skip_ack_i = ack;
    @(negedge clk);
    issue_i = 1'b0; skip_ack_i = 1'b0;
  endtask

  // Reference model: returns {we, res, cy, skip}
  function automatic logic [W+2:0] model(input logic [3:0] op,
      input logic [W-1:0] a, input logic [W-1:0] b, input logic cy);
    logic [W:0] s;
    logic we, c, sk;
    logic [W-1:0] r;
    we = 1'b0; r = '0; c = cy; sk = 1'b0;
    case (op)
      4'd0: begin s = a + b; we = 1; r = s[W-1:0]; sk = s[W]; end
      4'd1: begin s = a + b + cy; we = 1; r = s[W-1:0]; c = s[W]; end
      4'd2: begin we = 1; r = a & b; end
      4'd3: begin we = 1; r = a | b; end
      4'd4: begin we = 1; r = a ^ b; end
      4'd5: begin we = 1; r = {cy, a[W-1:1]}; c = a[0]; end
      4'd6: begin we = 1; r = ~a; end
      4'd7: begin we = 1; r = b + 1'b1; sk = (r == 0); end
      4'd8: begin we = 1; r = b - 1'b1; sk = (r == 4'hF); end
      4'd9: sk = (a == b);
      4'd10: c = 1'b1;
      4'd11: c = 1'b0;
      4'd12: c = ~cy;
      4'd13: sk = cy;
      default: ;
    endcase
    return {we, r, c, sk};
  endfunction

  task automatic t_reset_state;
    chk("R12 res", res_o, 0);
    chk("R12 we", res_we_o, 0);
    chk("R12 cy", cy_o, 0);
    chk("R12 skip", skip_o, 0);
  endtask

  task automatic t_exhaustive(input logic [3:0] op, input string tag);
    logic [W+2:0] e;
    for (int c = 0; c < 2; c++) begin
      for (int a = 0; a < 16; a++) begin
        for (int b = 0; b < 16; b++) begin
          issue(c ? 4'd10 : 4'd11, '0, '0, 1'b0);
          m_cy = c[0];
          e = model(op, a[W-1:0], b[W-1:0], m_cy);
          issue(op, a[W-1:0], b[W-1:0], 1'b0);
          if (e[W+2]) m_res = e[W+1:2];
          m_cy = e[1];
          chk({tag, " we"}, res_we_o, e[W+2]);
          chk({tag, " res"}, res_o, m_res);
          chk({tag, " cy"}, cy_o, e[1]);
          chk({tag, " skip"}, skip_o, e[0]);
        end
      end
    end
  endtask

  task automatic t_skip_latch;
    issue(4'd0, 4'hF, 4'h1, 1'b0);                 // carry out -> skip
    repeat (3) begin
      @(negedge clk);
      chk("R11 hold", skip_o, 1);
    end
    @(negedge clk); skip_ack_i = 1'b1;
    @(negedge clk); skip_ack_i = 1'b0;
    chk("R11 ack clears", skip_o, 0);
    issue(4'd7, 4'h0, 4'hF, 1'b0);                 // wraps -> skip
    chk("R11 set again", skip_o, 1);
    issue(4'd8, 4'h0, 4'h0, 1'b1);                 // issue beats ack, skips
    chk("R11 issue over ack", skip_o, 1);
    issue(4'd2, 4'h3, 4'h5, 1'b1);                 // no-skip op replaces
    chk("R11 replaced", skip_o, 0);
  endtask

  task automatic t_idle;
    issue(4'd3, 4'h9, 4'h4, 1'b0);
    chk("R1 or result", res_o, 4'hD);
    issue(4'd10, 4'h0, 4'h0, 1'b0);
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      op_i = 4'(i); acc_i = 4'(i * 3); opnd_i = 4'(i * 5);
      @(negedge clk);
      chk("R13 we idle", res_we_o, 0);
      chk("R13 res idle", res_o, 4'hD);
      chk("R13 cy idle", cy_o, 1);
    end
    issue(4'd14, 4'h1, 4'h2, 1'b0);
    chk("R1 code14 res", res_o, 4'hD);
    chk("R1 code14 cy", cy_o, 1);
    chk("R1 code14 we", res_we_o, 0);
  endtask

  task automatic t_reset_mid;
    issue(4'd10, 0, 0, 1'b0);
    issue(4'd13, 0, 0, 1'b0);
    chk("R10 sktc", skip_o, 1);
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    t_reset_state();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset_state();
    t_skip_latch();
    t_idle();
    t_exhaustive(4'd0, "R2 adds");
    t_exhaustive(4'd1, "R3 addc");
    t_exhaustive(4'd2, "R4 and");
    t_exhaustive(4'd3, "R4 or");
    t_exhaustive(4'd4, "R4 xor");
    t_exhaustive(4'd5, "R5 rorc");
    t_exhaustive(4'd6, "R6 not");
    t_exhaustive(4'd7, "R7 incs");
    t_exhaustive(4'd8, "R8 decs");
    t_exhaustive(4'd9, "R9 ske");
    t_exhaustive(4'd10, "R10 setc");
    t_exhaustive(4'd11, "R10 clrc");
    t_exhaustive(4'd12, "R10 notc");
    t_exhaustive(4'd13, "R10 sktc");
    t_exhaustive(4'd15, "R1 code15");
    t_reset_mid();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule